// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block feeds a MAC transmit path from buffers that software describes in a ring of two-word descriptors in system memory. Once software has written the ring's base address, raised the transmit enable and pulsed the start input, the engine reads each descriptor's control word, checks that the descriptor belongs to hardware, fetches its buffer pointer and streams the buffer's bytes out one per accepted beat. Buffers may start on any byte and hold from 1 to 2047 bytes. Several consecutive buffers are joined into one frame until a buffer marked as the frame's last.

When a frame is complete, the engine hands it back by rewriting the control word of the frame's first descriptor with the ownership bit set. It then moves on to the next descriptor. It stops when it meets a descriptor that software still owns. A zero-length buffer, a chain of more than 128 buffers, and a software-owned descriptor in the middle of a frame all abort the frame and flag an error in the returned control word. The ring returns to its base either on a wrap flag or after its last possible entry. CRC, preamble and the line interface belong to the MAC downstream.

Top module: `txq_engine`

## Requirements
- R1: After reset, tx_valid, mem_rd, mem_wr, frm_done and frm_err are all low.
- R2: Processing begins only on a cycle with xmit_go and xmit_en both high while the engine is idle. A start pulse while xmit_en is low causes no memory read.
- R3: Descriptor i lies at byte address ring_base + 8*i. Its word 0 (word address (ring_base>>2)+2i) is the buffer byte address. Its word 1 (the next word) holds the control fields: bit 31 is ownership (0 means hardware may send), bit 30 is wrap, bit 29 is error status, bit 15 is last buffer of frame, and bits 10:0 are the byte count. The engine reads word 1 before word 0.
- R4: If word 1 of the first descriptor of a frame has bit 31 set, the engine stops. It emits no byte and writes nothing, and it stays idle until a new start.
- R5: Each buffer yields exactly its byte count in bytes. Reading starts at the buffer's byte address, lower byte lanes of each 32-bit word come first, and buffers are joined in ring order.
- R6: tx_sof marks the first byte of a frame and tx_eof marks the final byte of the buffer with bit 15 set. A byte transfers only in a cycle with tx_valid and tx_ready both high, and the presented byte holds until then.
- R7: After the last byte of a frame, the engine writes word 1 of the frame's first descriptor back with bit 31 set, bit 29 clear and all other bits unchanged. It pulses frm_done for one cycle with frm_err low.
- R8: A descriptor with bit 30 set is followed by descriptor 0 at ring_base.
- R9: Without a wrap flag, the descriptor after index 1023 is descriptor 0.
- R10: A byte count of 0 aborts the frame without emitting that buffer. The returned word has bits 31 and 29 set, and frm_done and frm_err pulse together.
- R11: If the 128th buffer of a frame lacks bit 15, the frame is aborted: the first 127 buffers are streamed, no tx_eof is given, and the return word and frm_err flag the error.
- R12: A software-owned descriptor met after the first buffer of a frame aborts the frame with an error return, and the engine then stops on that descriptor.
- R13: With xmit_en low, the engine finishes the current frame, fetches no further descriptor, and restarts from descriptor 0 on the next start.
- R14: A memory read or write request holds its address until mem_ready, and a read and a write are never requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ring_base | input | 32 | Byte address of descriptor 0 (8-byte aligned) |
| xmit_en | input | 1 | Transmit enable |
| xmit_go | input | 1 | Start strobe |
| mem_rd | output | 1 | Read request |
| mem_addr | output | 30 | Read word address |
| mem_rdata | input | 32 | Read data, valid when mem_ready is high |
| mem_ready | input | 1 | Completes the pending read or write |
| mem_wr | output | 1 | Write request for descriptor return |
| mem_waddr | output | 30 | Write word address |
| mem_wdata | output | 32 | Returned control word |
| tx_valid | output | 1 | A byte is presented |
| tx_data | output | 8 | Byte to transmit |
| tx_sof | output | 1 | First byte of frame |
| tx_eof | output | 1 | Last byte of frame |
| tx_ready | input | 1 | MAC accepts the byte |
| frm_done | output | 1 | One-cycle pulse when a frame is returned |
| frm_err | output | 1 | With frm_done: the frame was aborted |

## Verification
Single-buffer frames are tried at word-aligned and odd start addresses, down to a single byte, which separates correct lane selection from mere word copying. Multi-buffer frames with mixed offsets and lengths up to 2047 bytes show whether buffer boundaries inside a word and across words are joined without gaps or repeats. Half of these patterns run with random stalls on both the memory and the byte stream, which exposes any request or byte that is not held steady. Rings of 1024 single-byte frames, an explicit wrap and an early enable drop tell apart the three ways the descriptor pointer can return to the base.

// File: rtl/txq_pkg.sv
package txq_pkg;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned LEN_W    = 11;
  localparam int unsigned OWN_BIT  = 31;
  localparam int unsigned WRAP_BIT = 30;
  localparam int unsigned ERR_BIT  = 29;
  localparam int unsigned LAST_BIT = 15;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTL,
    ST_PTR,
    ST_FILL,
    ST_EMIT,
    ST_RET
  } txq_state_e;

  typedef struct packed {
    logic             own;
    logic             wrap;
    logic             last;
    logic [LEN_W-1:0] len;
  } ctl_t;

  // Pull the control fields out of descriptor word 1.
  function automatic ctl_t ctl_decode(input logic [WORD_W-1:0] w);
    ctl_t c;
    c.own  = w[OWN_BIT];
    c.wrap = w[WRAP_BIT];
    c.last = w[LAST_BIT];
    c.len  = w[LEN_W-1:0];
    return c;
  endfunction

  // Control word handed back to software: owned by software, error as given.
  function automatic logic [WORD_W-1:0] ret_word(input logic [WORD_W-1:0] w,
                                                 input logic err);
    logic [WORD_W-1:0] r;
    r = w;
    r[OWN_BIT] = 1'b1;
    r[ERR_BIT] = err;
    return r;
  endfunction

  // True when a byte lane is the highest one of its word.
  function automatic logic lane_is_top(input logic [1:0] lane);
    return lane == 2'd3;
  endfunction

endpackage

// File: rtl/txq_ring_ptr.sv
module txq_ring_ptr #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned RING_N = 1024,
  parameter int unsigned IDX_W  = $clog2(RING_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base,
  input  logic              adv,
  input  logic              wrap,
  input  logic              clr,
  output logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-3:0] w0_addr,
  output logic [ADDR_W-3:0] w1_addr
);

  localparam int unsigned WA_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_next;
  logic             unused_base_lsb;

  assign unused_base_lsb = ^base[2:0];

  // Next entry: back to zero on a wrap flag or past the last slot.
  always_comb begin
    if (wrap || (idx_q == IDX_W'(RING_N - 1)))
      idx_next = '0;
    else
      idx_next = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idx_q <= '0;
    else if (clr)
      idx_q <= '0;
    else if (adv)
      idx_q <= idx_next;
  end

  assign idx     = idx_q;
  assign w0_addr = WA_W'({base[ADDR_W-1:3], 1'b0}) + WA_W'({idx_q, 1'b0});
  assign w1_addr = {w0_addr[WA_W-1:1], 1'b1};

endmodule

// File: rtl/txq_lane_sel.sv
module txq_lane_sel #(
  parameter int unsigned LANES = 4,
  parameter int unsigned SEL_W = $clog2(LANES)
) (
  input  logic [8*LANES-1:0] word,
  input  logic [SEL_W-1:0]   sel,
  output logic [7:0]         byte_o
);

  logic [7:0] lanes [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanes[g] = word[8*g +: 8];
  end

  assign byte_o = lanes[sel];

endmodule

// File: rtl/txq_engine.sv
module txq_engine
  import txq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned RING_N   = 1024,
  parameter int unsigned MAX_BUFS = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic              xmit_en,
  input  logic              xmit_go,
  output logic              mem_rd,
  output logic [ADDR_W-3:0] mem_addr,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ready,
  output logic              mem_wr,
  output logic [ADDR_W-3:0] mem_waddr,
  output logic [31:0]       mem_wdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_sof,
  output logic              tx_eof,
  input  logic              tx_ready,
  output logic              frm_done,
  output logic              frm_err
);

  localparam int unsigned WA_W  = ADDR_W - 2;
  localparam int unsigned IDX_W = $clog2(RING_N);
  localparam int unsigned CNT_W = $clog2(MAX_BUFS + 1);
  localparam int unsigned LANES = WORD_W / 8;
  localparam int unsigned SEL_W = $clog2(LANES);

  txq_state_e        state;
  logic [CNT_W-1:0]  nbuf;
  logic              err_q;
  logic              sof_pend;
  logic              last_q;
  logic [LEN_W-1:0]  rem;
  logic [ADDR_W-1:0] baddr;
  logic [31:0]       word_q;
  logic [31:0]       first_w1;
  logic [WA_W-1:0]   first_waddr;
  logic [WA_W-1:0]   cur_w0;

  // Named internal events, also observed by the checker.
  ctl_t              rd_ctl;
  logic              ev_ctl_ack;
  logic              ev_stop;
  logic              ev_orphan;
  logic              ev_take;
  logic              ev_zero;
  logic              ev_over;
  logic              ev_beat;
  logic              ev_buf_end;
  logic              ev_ret;
  logic              ptr_clr;
  logic              st_idle;
  logic [IDX_W-1:0]  ptr_idx;
  logic [WA_W-1:0]   ptr_w0;
  logic [WA_W-1:0]   ptr_w1;
  logic [7:0]        lane_byte;

  assign rd_ctl     = ctl_decode(mem_rdata);
  assign st_idle    = (state == ST_IDLE);
  assign ev_ctl_ack = (state == ST_CTL) && mem_ready;
  assign ev_stop    = ev_ctl_ack && rd_ctl.own && (nbuf == '0);
  assign ev_orphan  = ev_ctl_ack && rd_ctl.own && (nbuf != '0);
  assign ev_take    = ev_ctl_ack && !rd_ctl.own;
  assign ev_zero    = ev_take && (rd_ctl.len == '0);
  assign ev_over    = ev_take && (nbuf == CNT_W'(MAX_BUFS - 1)) && !rd_ctl.last;
  assign ev_beat    = (state == ST_EMIT) && tx_ready;
  assign ev_buf_end = ev_beat && (rem == LEN_W'(1));
  assign ev_ret     = (state == ST_RET) && mem_ready;
  assign ptr_clr    = (st_idle && !xmit_en) || (ev_ret && !xmit_en);

  txq_ring_ptr #(
    .ADDR_W (ADDR_W),
    .RING_N (RING_N),
    .IDX_W  (IDX_W)
  ) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .base    (ring_base),
    .adv     (ev_take),
    .wrap    (rd_ctl.wrap),
    .clr     (ptr_clr),
    .idx     (ptr_idx),
    .w0_addr (ptr_w0),
    .w1_addr (ptr_w1)
  );

  txq_lane_sel #(
    .LANES (LANES),
    .SEL_W (SEL_W)
  ) u_lane (
    .word   (word_q),
    .sel    (baddr[SEL_W-1:0]),
    .byte_o (lane_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      nbuf        <= '0;
      err_q       <= 1'b0;
      sof_pend    <= 1'b0;
      last_q      <= 1'b0;
      rem         <= '0;
      baddr       <= '0;
      word_q      <= '0;
      first_w1    <= '0;
      first_waddr <= '0;
      cur_w0      <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (xmit_en && xmit_go) state <= ST_CTL;
        end
        ST_CTL: begin
          if (ev_stop) begin
            state <= ST_IDLE;
          end else if (ev_orphan) begin
            err_q <= 1'b1;
            state <= ST_RET;
          end else if (ev_take) begin
            if (nbuf == '0) begin
              first_w1    <= mem_rdata;
              first_waddr <= ptr_w1;
              sof_pend    <= 1'b1;
            end
            if (ev_zero || ev_over) begin
              err_q <= 1'b1;
              state <= ST_RET;
            end else begin
              last_q <= rd_ctl.last;
              rem    <= rd_ctl.len;
              cur_w0 <= ptr_w0;
              state  <= ST_PTR;
            end
          end
        end
        ST_PTR: begin
          if (mem_ready) begin
            baddr <= mem_rdata[ADDR_W-1:0];
            nbuf  <= nbuf + 1'b1;
            state <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_ready) begin
            word_q <= mem_rdata;
            state  <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (ev_beat) begin
            sof_pend <= 1'b0;
            rem      <= rem - 1'b1;
            baddr    <= baddr + 1'b1;
            if (ev_buf_end)
              state <= last_q ? ST_RET : ST_CTL;
            else if (lane_is_top(baddr[1:0]))
              state <= ST_FILL;
          end
        end
        ST_RET: begin
          if (ev_ret) begin
            nbuf     <= '0;
            err_q    <= 1'b0;
            sof_pend <= 1'b0;
            state    <= xmit_en ? ST_CTL : ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Memory request side.
  always_comb begin
    mem_rd   = 1'b0;
    mem_addr = '0;
    unique case (state)
      ST_CTL:  begin mem_rd = 1'b1; mem_addr = ptr_w1;               end
      ST_PTR:  begin mem_rd = 1'b1; mem_addr = cur_w0;               end
      ST_FILL: begin mem_rd = 1'b1; mem_addr = baddr[ADDR_W-1:2];    end
      default: begin mem_rd = 1'b0; mem_addr = '0;                   end
    endcase
  end

  assign mem_wr    = (state == ST_RET);
  assign mem_waddr = first_waddr;
  assign mem_wdata = ret_word(first_w1, err_q);

  // Byte stream side.
  assign tx_valid = (state == ST_EMIT);
  assign tx_data  = lane_byte;
  assign tx_sof   = tx_valid && sof_pend;
  assign tx_eof   = tx_valid && last_q && (rem == LEN_W'(1));

  assign frm_done = ev_ret;
  assign frm_err  = ev_ret && err_q;

endmodule

// File: rtl/txq_checker.sv
module txq_checker #(
  parameter int unsigned WA_W  = 30,
  parameter int unsigned IDX_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             xmit_en,
  input logic             xmit_go,
  input logic             mem_rd,
  input logic [WA_W-1:0]  mem_addr,
  input logic             mem_ready,
  input logic             mem_wr,
  input logic [WA_W-1:0]  mem_waddr,
  input logic [31:0]      mem_wdata,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [7:0]       tx_data,
  input logic             tx_eof,
  input logic             frm_done,
  input logic             frm_err,
  input logic             ev_take,
  input logic             ev_stop,
  input logic             wrap_flag,
  input logic [IDX_W-1:0] ptr_idx,
  input logic             st_idle
);

  assert_rd_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && !mem_ready |=> mem_rd && $stable(mem_addr));

  assert_wr_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr && !mem_ready |=> mem_wr && $stable(mem_waddr) && $stable(mem_wdata));

  assert_rd_wr_excl_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_byte_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_eof));

  assert_eof_then_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_eof |=> !tx_valid && mem_wr);

  assert_return_owned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |-> mem_wr && mem_wdata[31] && (mem_wdata[29] == frm_err));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |=> !frm_done);

  assert_wrap_base_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_take && wrap_flag |=> ptr_idx == '0);

  assert_stop_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> st_idle && !mem_rd && !tx_valid);

  assert_no_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle && !(xmit_en && xmit_go) |=> !mem_rd);

endmodule

bind txq_engine txq_checker #(
  .WA_W  (WA_W),
  .IDX_W (IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .xmit_en   (xmit_en),
  .xmit_go   (xmit_go),
  .mem_rd    (mem_rd),
  .mem_addr  (mem_addr),
  .mem_ready (mem_ready),
  .mem_wr    (mem_wr),
  .mem_waddr (mem_waddr),
  .mem_wdata (mem_wdata),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_data   (tx_data),
  .tx_eof    (tx_eof),
  .frm_done  (frm_done),
  .frm_err   (frm_err),
  .ev_take   (ev_take),
  .ev_stop   (ev_stop),
  .wrap_flag (rd_ctl.wrap),
  .ptr_idx   (ptr_idx),
  .st_idle   (st_idle)
);

// File: tb/txq_engine_bench.sv
module txq_engine_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] ring_base;
  logic        xmit_en, xmit_go;
  logic        mem_rd, mem_ready, mem_wr;
  logic [29:0] mem_addr, mem_waddr;
  logic [31:0] mem_rdata, mem_wdata;
  logic        tx_valid, tx_sof, tx_eof, tx_ready;
  logic [7:0]  tx_data;
  logic        frm_done, frm_err;

  always #5 clk = ~clk;

  txq_engine u_txq_engine (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .xmit_en(xmit_en), .xmit_go(xmit_go),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .mem_wr(mem_wr), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_sof(tx_sof), .tx_eof(tx_eof),
    .tx_ready(tx_ready), .frm_done(frm_done), .frm_err(frm_err)
  );

  // Memory model: words 0..4095 hold descriptors, 4096..8191 buffer data.
  logic [31:0] mem [0:8191];
  assign mem_rdata = mem[mem_addr[12:0]];

  always @(posedge clk)
    if (mem_wr && mem_ready) mem[mem_waddr[12:0]] <= mem_wdata;

  // Stall generator, driven on the falling edge.
  logic [15:0] lfsr = 16'hACE1;
  logic        stall_on = 1'b0;
  always @(negedge clk) begin
    lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_ready  = !stall_on || lfsr[0] || lfsr[3];
    mem_ready = !stall_on || lfsr[1] || lfsr[5];
  end

  // Observation of the outputs.
  logic [7:0] cap_byte [0:8191];
  logic       cap_sof  [0:8191];
  logic       cap_eof  [0:8191];
  int         cap_n = 0, done_n = 0, err_n = 0, rd_cnt = 0;
  logic [29:0] last_raddr = '0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (tx_valid && tx_ready) begin
        cap_byte[cap_n[12:0]] <= tx_data;
        cap_sof[cap_n[12:0]]  <= tx_sof;
        cap_eof[cap_n[12:0]]  <= tx_eof;
        cap_n <= cap_n + 1;
      end
      if (frm_done) done_n <= done_n + 1;
      if (frm_err)  err_n  <= err_n + 1;
      if (mem_rd && mem_ready) begin
        rd_cnt     <= rd_cnt + 1;
        last_raddr <= mem_addr;
      end
    end
  end

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int w);
    logic [31:0] x;
    x = 32'(w) * 32'h9E37_79B1;
    return x ^ 32'h5A3C_0F96;
  endfunction

  function automatic logic [7:0] exp_byte(input int a);
    logic [31:0] w;
    w = pat(a / 4);
    return w[8*(a % 4) +: 8];
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Enable drop (pointer to base), then enable with a start pulse.
  task automatic kick(input int base);
    @(negedge clk);
    ring_base = 32'(base);
    xmit_en = 1'b0;
    @(negedge clk);
    xmit_en = 1'b1;
    xmit_go = 1'b1;
    @(negedge clk);
    xmit_go = 1'b0;
  endtask

  task automatic wait_done(input int target, input int limit);
    int k = 0;
    while (done_n < target && k < limit) begin
      @(negedge clk);
      k++;
    end
  endtask

  function automatic int eof_count(input int from, input int upto);
    int c = 0;
    for (int i = from; i < upto; i++) if (cap_eof[i[12:0]]) c++;
    return c;
  endfunction

  // Vector table: base, buffer count, then (address, length) per buffer.
  localparam int VT [0:5][0:7] = '{
    '{32'h000, 1, 32'h4000,    4,        0, 0,        0, 0},
    '{32'h040, 1, 32'h4011,    1,        0, 0,        0, 0},
    '{32'h080, 2, 32'h4103,    6, 32'h4202, 5,        0, 0},
    '{32'h100, 3, 32'h4301,    3, 32'h4400, 8, 32'h4507, 2},
    '{32'h000, 1, 32'h4600, 2047,        0, 0,        0, 0},
    '{32'h200, 2, 32'h5002,    9, 32'h6001, 1,        0, 0}
  };

  initial begin
    int mark, d0, e0, r0, total, k, bw;
    bit ok_val, ok_flag;
    logic [31:0] orig;

    rst_n = 1'b0; xmit_en = 1'b0; xmit_go = 1'b0; ring_base = '0;
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    for (int i = 4096; i < 8192; i++) mem[i] = pat(i);
    idle(4);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    chk(!tx_valid && !mem_rd && !mem_wr && !frm_done && !frm_err, "R1", "idle outputs",
        {tx_valid, mem_rd, mem_wr, frm_done, frm_err}, 0);

    // R2 start ignored while disabled
    r0 = rd_cnt;
    @(negedge clk); xmit_go = 1'b1;
    @(negedge clk); xmit_go = 1'b0;
    idle(20);
    chk(rd_cnt == r0, "R2", "reads after start with enable low", rd_cnt - r0, 0);

    // Table walk: R3 R5 R6 R7
    for (int v = 0; v < 6; v++) begin
      bw = VT[v][0] / 4;
      stall_on = v[0];
      mark = cap_n; d0 = done_n; e0 = err_n; total = 0;
      for (int i = 0; i < VT[v][1]; i++) begin
        mem[bw + 2*i]     = 32'(VT[v][2 + 2*i]);
        mem[bw + 2*i + 1] = 32'(VT[v][3 + 2*i]) | 32'h0010_0000 |
                            ((i == VT[v][1] - 1) ? 32'h0000_8000 : 32'h0);
        total += VT[v][3 + 2*i];
      end
      mem[bw + 2*VT[v][1] + 1] = 32'h8000_0000;
      orig = mem[bw + 1];
      kick(VT[v][0]);
      wait_done(d0 + 1, 20000);
      idle(20);
      ok_val = 1; ok_flag = 1; k = 0;
      for (int i = 0; i < VT[v][1]; i++)
        for (int j = 0; j < VT[v][3 + 2*i]; j++) begin
          if (cap_byte[(mark + k) % 8192] != exp_byte(VT[v][2 + 2*i] + j)) ok_val = 0;
          if (cap_sof[(mark + k) % 8192] != (k == 0)) ok_flag = 0;
          if (cap_eof[(mark + k) % 8192] != (k == total - 1)) ok_flag = 0;
          k++;
        end
      chk(cap_n - mark == total, "R5", $sformatf("vector %0d byte count", v), cap_n - mark, total);
      chk(ok_val, "R5", $sformatf("vector %0d byte values (R3 layout)", v), ok_val, 1);
      chk(ok_flag, "R6", $sformatf("vector %0d sof/eof placement", v), ok_flag, 1);
      chk(mem[bw + 1] == (orig | 32'h8000_0000), "R7", $sformatf("vector %0d return word", v),
          mem[bw + 1], orig | 32'h8000_0000);
      chk(done_n - d0 == 1 && err_n == e0, "R7", $sformatf("vector %0d done/err pulses", v),
          {done_n - d0, err_n - e0}, 64'h1_0000_0000);
    end
    stall_on = 0;

    // R4 first descriptor owned by software
    mem[1536 + 1] = 32'h8000_8001;
    r0 = rd_cnt; mark = cap_n; d0 = done_n;
    kick(32'h1800);
    idle(20);
    chk(rd_cnt - r0 == 1 && cap_n == mark && done_n == d0, "R4", "stop on owned descriptor",
        {rd_cnt - r0, cap_n - mark, done_n - d0}, 1 << 64);
    chk(mem[1537] == 32'h8000_8001, "R4", "owned descriptor untouched", mem[1537], 32'h8000_8001);

    // R8 explicit wrap
    mem[512] = 32'h4000; mem[513] = 32'h0000_8002;
    mem[514] = 32'h4004; mem[515] = 32'h4000_8003;
    mem[516] = 32'h4008; mem[517] = 32'h0000_8001;
    mark = cap_n; d0 = done_n;
    kick(32'h800);
    wait_done(d0 + 2, 2000);
    idle(20);
    chk(cap_n - mark == 5 && done_n - d0 == 2, "R8", "two frames before wrap",
        cap_n - mark, 5);
    chk(last_raddr == 30'd513 && mem[517][31] == 1'b0, "R8", "wrap returns to base",
        last_raddr, 513);

    // R9 implicit wrap after 1024 entries
    for (int i = 0; i < 1024; i++) begin
      mem[2*i] = 32'h4000; mem[2*i + 1] = 32'h0000_8001;
    end
    mark = cap_n; d0 = done_n;
    kick(0);
    wait_done(d0 + 1024, 60000);
    idle(20);
    chk(done_n - d0 == 1024 && cap_n - mark == 1024, "R9", "frames in full ring",
        done_n - d0, 1024);
    chk(last_raddr == 30'd1 && mem[2047][31] == 1'b1, "R9", "pointer back at base",
        last_raddr, 1);

    // R10 zero length
    mem[1536] = 32'h4000; mem[1537] = 32'h0010_8000; mem[1539] = 32'h8000_0000;
    mark = cap_n; d0 = done_n; e0 = err_n;
    kick(32'h1800);
    wait_done(d0 + 1, 2000);
    idle(20);
    chk(cap_n == mark && done_n - d0 == 1 && err_n - e0 == 1, "R10", "zero length abort",
        {cap_n - mark, done_n - d0, err_n - e0}, 64'h1_0000_0001);
    chk(mem[1537] == 32'hA010_8000, "R10", "error return word", mem[1537], 32'hA010_8000);

    // R11 too many buffers
    for (int i = 0; i < 128; i++) begin
      mem[2*i] = 32'h4000; mem[2*i + 1] = 32'h0010_0001;
    end
    mem[257] = 32'h8000_0000;
    mark = cap_n; d0 = done_n; e0 = err_n;
    kick(0);
    wait_done(d0 + 1, 5000);
    idle(20);
    chk(cap_n - mark == 127 && eof_count(mark, cap_n) == 0, "R11", "127 bytes and no eof",
        cap_n - mark, 127);
    chk(err_n - e0 == 1 && mem[1] == 32'hA010_0001, "R11", "error return word",
        mem[1], 32'hA010_0001);

    // R12 software-owned descriptor mid-frame
    mem[1536] = 32'h4000; mem[1537] = 32'h0010_0002; mem[1539] = 32'h8000_0000;
    mark = cap_n; d0 = done_n; e0 = err_n; r0 = rd_cnt;
    kick(32'h1800);
    wait_done(d0 + 1, 2000);
    idle(20);
    chk(cap_n - mark == 2 && eof_count(mark, cap_n) == 0 && err_n - e0 == 1, "R12",
        "mid-frame abort", cap_n - mark, 2);
    chk(mem[1537] == 32'hA010_0002 && mem[1539] == 32'h8000_0000 && last_raddr == 30'd1539,
        "R12", "return word and stop", mem[1537], 32'hA010_0002);

    // R13 enable dropped during a frame
    mem[1024] = 32'h4000; mem[1025] = 32'h0000_80C8;
    mem[1026] = 32'h4000; mem[1027] = 32'h0000_8001;
    mem[1029] = 32'h8000_0000;
    mark = cap_n; d0 = done_n;
    kick(32'h1000);
    while (cap_n < mark + 5) @(negedge clk);
    xmit_en = 1'b0;
    wait_done(d0 + 1, 2000);
    idle(30);
    chk(done_n - d0 == 1 && cap_n - mark == 200 && mem[1027][31] == 1'b0, "R13",
        "frame finished, next not fetched", done_n - d0, 1);
    @(negedge clk); xmit_en = 1'b1; xmit_go = 1'b1;
    @(negedge clk); xmit_go = 1'b0;
    idle(20);
    chk(last_raddr == 30'd1025 && done_n - d0 == 1, "R13", "restart from base",
        last_raddr, 1025);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 190000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule